// File: doc/BRIEF.md
# PCI INTx Interrupt Router

This block collects level-sensitive legacy PCI interrupt requests (INTA to INTD) from a set of device slots and folds each one onto one of four shared PIRQ lines. The line is picked from the slot's device number and interrupt pin. Every PIRQ line then drives two targets. The first is one of sixteen legacy IRQ outputs, chosen by a programmable route byte for that line. The second is a fixed IOAPIC input (PIRQ k goes to IOAPIC input 16+k, brought out as `ioapic_pin[k]`).

Several devices may share a PIRQ line, and several PIRQ lines may share a legacy IRQ. An output stays high while any source behind it is still requesting. The two targets of a line are sequenced. On a rising request the legacy IRQ goes up one cycle before the IOAPIC input. On a falling request the IOAPIC input drops one cycle before the legacy IRQ.

Requests are plain levels and have no handshake, so there is no back-pressure on them. The route-byte port is a one-cycle write strobe with a combinational read. A write is always accepted on the edge where it is presented and is never stalled.

Top module: `pci_intx_router`

## Requirements
- R1: A slot whose 3-bit pin field `p` holds 1 (INTA) to 4 (INTD) and whose device number is `d` maps to PIRQ index `(p - 1 + d - 1) mod 4`. Only `d mod 4` affects the result.
- R2: A slot whose pin field is 0 (no interrupt pin) or 5 to 7 contributes to no PIRQ line, whatever its level.
- R3: A PIRQ line counts as requested in a cycle when at least one slot mapped to it has its level high. Dropping one requester leaves the line up while another mapped requester is still high.
- R4: `ioapic_pin[k]` is high exactly when PIRQ k was requested at both of the two most recent clock edges. This does not depend on the route byte of line k.
- R5: Each route byte has this layout: bits [3:0] give the legacy IRQ number, bits [6:4] are reserved and read back as written, and bit 7 is a disable flag. When the whole byte is 16 or more (bit 7 set, or any reserved bit set), the line drives no legacy IRQ.
- R6: `legacy_irq[i]` is high exactly when some PIRQ k has a route byte below 16 with bits [3:0] equal to i, and k was requested at either of the two most recent clock edges. Lines that share an IRQ are ORed.
- R7: When a request rises, the routed legacy IRQ rises one cycle before `ioapic_pin[k]`. When it falls, `ioapic_pin[k]` falls one cycle before the routed legacy IRQ.
- R8: A route byte written while its line is active moves the legacy output to the new IRQ, or removes it, directly after the write edge. The old IRQ drops unless another line still drives it.
- R9: After reset, all four route bytes read 0x80 and `legacy_irq` and `ioapic_pin` are all zero.
- R10: With `reg_wr_en` high at a clock edge, `reg_wdata` is stored in route byte `reg_addr` (0 to 3 selects PIRQ 0 to 3). `reg_rdata` always shows route byte `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_dev | input | NUM_SLOTS*DEV_W | Device number per slot, slot s in bits [s*DEV_W +: DEV_W] |
| req_pin | input | NUM_SLOTS*3 | Interrupt pin per slot (0 none, 1..4 INTA..INTD), slot s in bits [s*3 +: 3] |
| req_level | input | NUM_SLOTS | Request level per slot, high = asserted |
| reg_wr_en | input | 1 | Route byte write strobe |
| reg_addr | input | 2 | Route byte select, equal to the PIRQ index |
| reg_wdata | input | 8 | Route byte write data |
| reg_rdata | output | 8 | Selected route byte |
| legacy_irq | output | 16 | Legacy IRQ lines 0..15 |
| ioapic_pin | output | 4 | IOAPIC inputs 16..19, bit k for PIRQ k |

## Verification
The bound checker watches four things on every cycle:
- An IOAPIC input may be high only after two cycles of request on its line.
- The legacy-before-IOAPIC order holds on both edges of a request, wherever the route byte is live.
- Fully disabled routing keeps every legacy line low.
- A written byte reads back on the next cycle, and invalid pins never raise a line.

The bench's cycle reference model carries the rest: the exact swizzle for each device and pin, sharing of lines and IRQs while requesters come and go, and rerouting of an active line. Those can only be shown by scenarios in which several slots and route writes interact.

// File: rtl/pci_intx_router_pkg.sv
package pci_intx_router_pkg;
  localparam int PIRQ_N      = 4;
  localparam int IRQ_N       = 16;
  localparam int IRQ_SEL_W   = $clog2(IRQ_N);
  localparam int PIN_W       = 3;
  localparam int ROUTE_W     = 8;
  localparam int RADDR_W     = $clog2(PIRQ_N);

  typedef logic [ROUTE_W-1:0] route_t;

  localparam route_t ROUTE_RESET = 8'h80;

  // pin 1..4 are INTA..INTD; anything else carries no request
  function automatic logic pin_is_valid(input logic [PIN_W-1:0] pin);
    return (pin != '0) && (pin <= PIN_W'(PIRQ_N));
  endfunction

  // a route byte drives a legacy IRQ only when its full value is below 16
  function automatic logic route_is_live(input route_t r);
    return r < route_t'(IRQ_N);
  endfunction
endpackage

// File: rtl/intx_swizzle.sv
module intx_swizzle
  import pci_intx_router_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DEV_W     = 5
) (
  input  logic [NUM_SLOTS*DEV_W-1:0] req_dev,
  input  logic [NUM_SLOTS*PIN_W-1:0] req_pin,
  input  logic [NUM_SLOTS-1:0]       req_level,
  output logic [PIRQ_N-1:0]          pirq_req
);
  localparam int SUM_W = DEV_W + 1;

  logic [NUM_SLOTS-1:0][PIRQ_N-1:0] slot_hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [PIN_W-1:0]   pin_s;
    logic [DEV_W-1:0]   dev_s;
    logic [RADDR_W-1:0] idx_s;
    logic [PIRQ_N-1:0]  hit_s;

    assign pin_s = req_pin[s*PIN_W +: PIN_W];
    assign dev_s = req_dev[s*DEV_W +: DEV_W];
    // (pin-1)+(dev-1) mod 4 equals pin+dev+2 mod 4
    assign idx_s = RADDR_W'({1'b0, dev_s} + SUM_W'(pin_s) + SUM_W'(2));

    always_comb begin
      hit_s = '0;
      if (req_level[s] && pin_is_valid(pin_s)) hit_s[idx_s] = 1'b1;
    end

    assign slot_hit[s] = hit_s;
  end

  always_comb begin
    pirq_req = '0;
    for (int s = 0; s < NUM_SLOTS; s++) pirq_req = pirq_req | slot_hit[s];
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pci_intx_router_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [RADDR_W-1:0]      addr,
  input  route_t                  wdata,
  output route_t                  rdata,
  output route_t [PIRQ_N-1:0]     route_q
);
  for (genvar k = 0; k < PIRQ_N; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[k] <= ROUTE_RESET;
      else if (wr_en && addr == RADDR_W'(k)) route_q[k] <= wdata;
    end
  end

  assign rdata = route_q[addr];
endmodule

// File: rtl/pirq_stager.sv
module pirq_stager
  import pci_intx_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIRQ_N-1:0] pirq_req,
  output logic [PIRQ_N-1:0] leg_act,
  output logic [PIRQ_N-1:0] io_act
);
  logic [PIRQ_N-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pirq_req;
      stage2_q <= stage1_q;
    end
  end

  // legacy: rises with the newest sample, falls with the older one
  assign leg_act = stage1_q | stage2_q;
  // IOAPIC: rises with the older sample, falls with the newest one
  assign io_act  = stage1_q & stage2_q;
endmodule

// File: rtl/legacy_irq_map.sv
module legacy_irq_map
  import pci_intx_router_pkg::*;
(
  input  logic [PIRQ_N-1:0]   leg_act,
  input  route_t [PIRQ_N-1:0] route_q,
  output logic [IRQ_N-1:0]    legacy_irq
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < PIRQ_N; k++) begin
        if (leg_act[k] && route_is_live(route_q[k]) &&
            route_q[k][IRQ_SEL_W-1:0] == IRQ_SEL_W'(i))
          hit = 1'b1;
      end
    end
    assign legacy_irq[i] = hit;
  end
endmodule

// File: rtl/pci_intx_router.sv
module pci_intx_router
  import pci_intx_router_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DEV_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS*DEV_W-1:0] req_dev,
  input  logic [NUM_SLOTS*3-1:0]     req_pin,
  input  logic [NUM_SLOTS-1:0]       req_level,
  input  logic                       reg_wr_en,
  input  logic [1:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  output logic [15:0]                legacy_irq,
  output logic [3:0]                 ioapic_pin
);
  logic [PIRQ_N-1:0]   pirq_req;
  logic [PIRQ_N-1:0]   leg_act;
  route_t [PIRQ_N-1:0] route_q;

  intx_swizzle #(.NUM_SLOTS(NUM_SLOTS), .DEV_W(DEV_W)) u_swz (
    .req_dev  (req_dev),
    .req_pin  (req_pin),
    .req_level(req_level),
    .pirq_req (pirq_req)
  );

  pirq_route_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .route_q(route_q)
  );

  pirq_stager u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .pirq_req(pirq_req),
    .leg_act (leg_act),
    .io_act  (ioapic_pin)
  );

  legacy_irq_map u_map (
    .leg_act   (leg_act),
    .route_q   (route_q),
    .legacy_irq(legacy_irq)
  );
endmodule

// File: rtl/pci_intx_router_chk.sv
module pci_intx_router_chk
  import pci_intx_router_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr_en,
  input logic [1:0]             reg_addr,
  input logic [7:0]             reg_wdata,
  input logic [7:0]             reg_rdata,
  input logic [NUM_SLOTS*3-1:0] req_pin,
  input logic [15:0]            legacy_irq,
  input logic [3:0]             ioapic_pin,
  input logic [PIRQ_N-1:0]      pirq_req,
  input route_t [PIRQ_N-1:0]    route_q
);
  logic any_pin_ok;
  logic all_routes_off;

  always_comb begin
    any_pin_ok = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (pin_is_valid(req_pin[s*3 +: 3])) any_pin_ok = 1'b1;
  end

  always_comb begin
    all_routes_off = 1'b1;
    for (int k = 0; k < PIRQ_N; k++)
      if (route_q[k] < 8'd16) all_routes_off = 1'b0;
  end

  for (genvar k = 0; k < PIRQ_N; k++) begin : g_line
    assert_ioapic_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ioapic_pin[k] |-> ($past(pirq_req[k]) && $past(pirq_req[k], 2)));

    assert_legacy_rises_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ioapic_pin[k]) && route_q[k] < 8'd16 && $stable(route_q[k]))
        |-> $past(legacy_irq[route_q[k][3:0]]));

    assert_ioapic_falls_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ioapic_pin[k]) && route_q[k] < 8'd16) |-> legacy_irq[route_q[k][3:0]]);
  end

  assert_disabled_no_legacy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    all_routes_off |-> (legacy_irq == 16'h0000));

  assert_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr_en) && reg_addr == $past(reg_addr))
      |-> (reg_rdata == $past(reg_wdata)));

  assert_bad_pin_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pin_ok |-> (pirq_req == '0));
endmodule

bind pci_intx_router pci_intx_router_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .req_pin   (req_pin),
  .legacy_irq(legacy_irq),
  .ioapic_pin(ioapic_pin),
  .pirq_req  (pirq_req),
  .route_q   (route_q)
);

// File: tb/sim_pci_intx_router.sv
`timescale 1ns/1ps
module sim_pci_intx_router;
  localparam int NS = 4;
  localparam int DW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS*DW-1:0] req_dev = '0;
  logic [NS*3-1:0]  req_pin = '0;
  logic [NS-1:0]    req_level = '0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [15:0]   legacy_irq;
  logic [3:0]    ioapic_pin;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_route [4];
  bit m_r1 [4];
  bit m_r2 [4];

  always #10 clk = ~clk;

  pci_intx_router #(.NUM_SLOTS(NS), .DEV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_dev(req_dev), .req_pin(req_pin),
    .req_level(req_level), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .legacy_irq(legacy_irq), .ioapic_pin(ioapic_pin)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_route[k] = 128; m_r1[k] = 0; m_r2[k] = 0;
      end
    end else begin
      bit now [4];
      for (int k = 0; k < 4; k++) now[k] = 0;
      for (int s = 0; s < NS; s++) begin
        int p, d;
        p = int'(req_pin[s*3 +: 3]);
        d = int'(req_dev[s*DW +: DW]);
        if (req_level[s] && p >= 1 && p <= 4) now[((p - 1) + (d + 3)) % 4] = 1;
      end
      for (int k = 0; k < 4; k++) begin
        m_r2[k] = m_r1[k];
        m_r1[k] = now[k];
      end
      if (reg_wr_en) m_route[reg_addr] = int'(reg_wdata);
    end
  end

  function automatic logic [15:0] exp_legacy();
    logic [15:0] e = '0;
    for (int k = 0; k < 4; k++)
      if ((m_r1[k] || m_r2[k]) && m_route[k] < 16) e[m_route[k]] = 1'b1;
    return e;
  endfunction

  function automatic logic [3:0] exp_ioapic();
    logic [3:0] e = '0;
    for (int k = 0; k < 4; k++) e[k] = m_r1[k] && m_r2[k];
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(legacy_irq == exp_legacy(), "R6 legacy model", legacy_irq, exp_legacy());
      chk(ioapic_pin == exp_ioapic(), "R4 ioapic model", ioapic_pin, exp_ioapic());
      chk(reg_rdata == 8'(m_route[reg_addr]), "R10 readback model", reg_rdata,
          m_route[reg_addr]);
    end
  end

  task automatic set_slot(input int s, input int dev, input int pin, input bit lvl);
    req_dev[s*DW +: DW] = DW'(dev);
    req_pin[s*3 +: 3]   = 3'(pin);
    req_level[s]        = lvl;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #2;
    reg_wr_en = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk); #2;
    reg_wr_en = 1'b0;
  endtask

  task automatic drive_edge();
    @(negedge clk); #2;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    wait_neg(1);
    // R9: reset state
    chk(legacy_irq == 16'h0, "R9 legacy after reset", legacy_irq, 0);
    chk(ioapic_pin == 4'h0, "R9 ioapic after reset", ioapic_pin, 0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      chk(reg_rdata == 8'h80, "R9 route byte after reset", reg_rdata, 8'h80);
    end
    cmp_en = 1'b1;

    wr(0, 8'h05); wr(1, 8'h0A); wr(2, 8'h05); wr(3, 8'h25);
    reg_addr = 2'd3; #1;
    chk(reg_rdata == 8'h25, "R5 reserved bits read back", reg_rdata, 8'h25);

    // R1: dev 3, INTB -> PIRQ 3 (route byte 0x25 is disabled by reserved bits)
    drive_edge(); set_slot(0, 3, 2, 1);
    wait_neg(1);
    chk(ioapic_pin == 4'h0, "R4 ioapic waits second edge", ioapic_pin, 0);
    chk(legacy_irq == 16'h0, "R5 reserved bits disable legacy", legacy_irq, 0);
    wait_neg(1);
    chk(ioapic_pin == 4'b1000, "R1 swizzle dev3 INTB", ioapic_pin, 4'b1000);
    drive_edge(); set_slot(0, 3, 2, 0);
    wait_neg(2);

    // R7: dev 1, INTA -> PIRQ 0 -> IRQ5
    drive_edge(); set_slot(1, 1, 1, 1);
    wait_neg(1);
    chk(legacy_irq == 16'h0020, "R7 legacy rises first", legacy_irq, 16'h0020);
    chk(ioapic_pin == 4'h0, "R7 ioapic not yet", ioapic_pin, 0);
    wait_neg(1);
    chk(ioapic_pin == 4'b0001, "R1 swizzle dev1 INTA", ioapic_pin, 4'b0001);
    drive_edge(); set_slot(1, 1, 1, 0);
    wait_neg(1);
    chk(ioapic_pin == 4'h0, "R7 ioapic falls first", ioapic_pin, 0);
    chk(legacy_irq == 16'h0020, "R7 legacy held one more cycle", legacy_irq, 16'h0020);
    wait_neg(1);
    chk(legacy_irq == 16'h0, "R7 legacy falls second", legacy_irq, 0);

    // R3: two requesters on PIRQ 0 (dev1 INTA, dev2 INTD)
    drive_edge(); set_slot(1, 1, 1, 1); set_slot(2, 2, 4, 1);
    wait_neg(2);
    drive_edge(); set_slot(1, 1, 1, 0);
    wait_neg(3);
    chk(ioapic_pin == 4'b0001, "R3 line held by remaining requester", ioapic_pin, 4'b0001);
    chk(legacy_irq == 16'h0020, "R3 legacy held by remaining requester", legacy_irq,
        16'h0020);

    // R6: dev3 INTA -> PIRQ 2 also routed to IRQ5
    drive_edge(); set_slot(3, 3, 1, 1);
    wait_neg(2);
    chk(ioapic_pin == 4'b0101, "R6 two lines active", ioapic_pin, 4'b0101);
    drive_edge(); set_slot(2, 2, 4, 0);
    wait_neg(3);
    chk(legacy_irq == 16'h0020, "R6 shared IRQ held by other line", legacy_irq, 16'h0020);
    chk(ioapic_pin == 4'b0100, "R4 only PIRQ2 remains", ioapic_pin, 4'b0100);

    // R8: reroute active PIRQ 2 to IRQ12, then disable it
    wr(2, 8'h0C);
    chk(legacy_irq == 16'h1000, "R8 reroute moves legacy", legacy_irq, 16'h1000);
    wr(2, 8'h80);
    chk(legacy_irq == 16'h0, "R8 disable removes legacy", legacy_irq, 0);
    chk(ioapic_pin == 4'b0100, "R4 ioapic ignores route byte", ioapic_pin, 4'b0100);
    drive_edge(); set_slot(3, 3, 1, 0);
    wait_neg(2);

    // R2: pin 0 and pin 6 ignored
    wr(2, 8'h07);
    drive_edge(); set_slot(0, 1, 0, 1); set_slot(1, 2, 6, 1);
    wait_neg(3);
    chk(ioapic_pin == 4'h0, "R2 invalid pins raise no line", ioapic_pin, 0);
    chk(legacy_irq == 16'h0, "R2 invalid pins raise no IRQ", legacy_irq, 0);
    drive_edge(); req_level = '0;

    // random phase, compared against the model on every clock
    for (int c = 0; c < 4000; c++) begin
      drive_edge();
      for (int s = 0; s < NS; s++)
        set_slot(s, int'($urandom_range(0, 31)), int'($urandom_range(0, 7)),
                 ($urandom_range(0, 3) != 0));
      reg_addr = 2'($urandom_range(0, 3));
      reg_wr_en = ($urandom_range(0, 7) == 0);
      reg_wdata = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                              : 8'($urandom_range(0, 15));
    end
    drive_edge(); reg_wr_en = 1'b0; req_level = '0;
    wait_neg(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule